// File: doc/BRIEF.md
# Record-Mark Block Transfer Channel

This block moves a whole message between a word-addressed memory and a serial line control, one character at a time, without per-character software work. A start command gives a base address, a direction and a character width. The channel then walks memory upward from the base. It fetches characters for the line when transmitting and stores received characters when receiving. It stops when it meets a location whose two tag bits are both set (a record mark). Memory words hold six data bits. A character wider than six bits therefore occupies two consecutive locations.

If no character moves on the line for a programmable number of clock cycles while the channel is held, the channel lets go on its own and flags a timeout error. After every release, a device-busy output stays high for two extra cycles. On transmit, an interrupt request follows once the line reports that its last character has left. On receive, a demand pulse marks the first character of each message.

Top module: `rm_block_chan`

## Requirements
- R1: After reset, chan_busy_o, dev_busy_o, released_o, timeout_err_o, in_demand_o, tx_irq_o, tx_valid_o, mem_we_o and mem_re_o are all 0.
- R2: Narrow transmit (start_dir_i=1, start_wide_i=0) reads locations base, base+1, and so on, and offers each unmarked location as one character with bits 7:6 zero. A record mark at base+n ends the message after exactly n characters.
- R3: Wide transmit (start_wide_i=1) builds character k from two locations. Bits 1:0 of location base+2k become character bits 7:6, and bits 5:0 of base+2k+1 become character bits 5:0. Only the first location of each pair is tested for a mark, so a mark at base+2n ends after n characters.
- R4: Narrow receive (start_dir_i=0) stores bits 5:0 of each received character at successive locations from base, leaving the tag bits untouched. A mark at base+n-1 releases the channel after the n-th character has been stored there.
- R5: Wide receive stores bits 7:6 of character k in bits 1:0 of base+2k, with the upper bits zero, and bits 5:0 of the character at base+2k+1. The mark is tested on the second location of the pair, so a mark at base+2n-1 ends after n characters.
- R6: A location terminates a transfer only if both mem_imark_i and mem_wmark_i are 1. Either tag alone is treated as ordinary data.
- R7: released_o is a single-cycle pulse in the first cycle that chan_busy_o is low after a transfer.
- R8: in_demand_o pulses once per receive message, for the first character only.
- R9: If TIMEOUT_CYC cycles pass with no line character while the channel is busy, the channel is released and timeout_err_o is set. The error stays set until the next accepted start.
- R10: dev_busy_o is high whenever chan_busy_o is high, and stays high for exactly 2 cycles after chan_busy_o falls.
- R11: After a transmit release, tx_irq_o pulses once, but only when line_idle_i is 1. A receive transfer raises no tx_irq_o.
- R12: A start while the channel is busy is ignored. A received character while the channel is idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command strobe |
| start_dir_i | input | 1 | 1 = transmit (memory to line), 0 = receive |
| start_wide_i | input | 1 | 1 = characters of 7 or 8 bits, two locations each |
| start_base_i | input | ADDR_W | First memory location of the message |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_re_o | output | 1 | Read request; data returns next cycle |
| mem_we_o | output | 1 | Write request for the data bits |
| mem_wdata_o | output | 6 | Write data |
| mem_rdata_i | input | 6 | Read data |
| mem_imark_i | input | 1 | Item tag of the read location |
| mem_wmark_i | input | 1 | Word tag of the read location |
| rx_valid_i | input | 1 | One-cycle strobe: a character arrived from the line |
| rx_char_i | input | 8 | Received character |
| tx_valid_o | output | 1 | Character offered to the line |
| tx_char_o | output | 8 | Character to send |
| tx_ready_i | input | 1 | Line accepts the offered character |
| line_idle_i | input | 1 | Line serializer is empty |
| chan_busy_o | output | 1 | Channel held by a transfer |
| dev_busy_o | output | 1 | Unit busy, extended past the channel |
| released_o | output | 1 | Release pulse |
| timeout_err_o | output | 1 | Release was forced by inactivity |
| in_demand_o | output | 1 | First received character of a message |
| tx_irq_o | output | 1 | Transmit completion request |

## Verification
Transmit runs in narrow and wide mode. The narrow run places single-tag locations ahead of the true mark, which separates a proper two-tag match from a one-tag match. The wide run puts a full mark on the second location of a pair, which separates pair-aligned mark testing from testing every location. Receive runs in both widths check the exact bits stored and that the marked location itself is written. A stray character after release and a start command during a transfer show that both are ignored. A receive with no reachable mark exercises the forced release and the error flag that stays set. Holding the line busy after a transmit shows that the interrupt waits for the line to go idle.

// File: rtl/rm_chan_pkg.sv
package rm_chan_pkg;
  localparam int unsigned FRAME_W = 6;
  localparam int unsigned CHAR_W  = 8;
  localparam int unsigned HI_W    = CHAR_W - FRAME_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TX_RD,
    ST_TX_CHK,
    ST_TX_LO,
    ST_TX_SEND,
    ST_RX_WAIT,
    ST_RX_HI,
    ST_RX_RD,
    ST_RX_CHK
  } seq_state_e;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/rm_idle_watchdog.sv
module rm_idle_watchdog #(
  parameter int unsigned LIMIT = 1500000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || kick_i)  cnt_q <= '0;
    else if (cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && !kick_i && (cnt_q == LAST);
endmodule

// File: rtl/rm_busy_tail.sv
module rm_busy_tail #(
  parameter int unsigned TAIL = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic busy_o
);
  localparam int unsigned W = $clog2(TAIL + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (busy_i)      cnt_q <= W'(TAIL);
    else if (cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = busy_i || (cnt_q != 0);
endmodule

// File: rtl/rm_xfer_seq.sv
module rm_xfer_seq
  import rm_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               dir_i,
  input  logic               wide_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic               expire_i,
  input  logic [FRAME_W-1:0] mem_rdata_i,
  input  logic               mem_mark_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_re_o,
  output logic               mem_we_o,
  output logic [FRAME_W-1:0] mem_wdata_o,
  input  logic               rx_valid_i,
  input  logic [CHAR_W-1:0]  rx_char_i,
  input  logic               tx_ready_i,
  output logic               tx_valid_o,
  output logic [CHAR_W-1:0]  tx_char_o,
  output logic               busy_o,
  output xfer_dir_e          dir_o,
  output logic               start_ok_o,
  output logic               done_o,
  output logic               done_to_o,
  output logic               accept_o
);
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q;
  logic              wide_q;
  xfer_dir_e         dir_q;
  logic [HI_W-1:0]   hi_q;
  logic [CHAR_W-1:0] char_q;

  always_comb begin
    state_d     = state_q;
    mem_addr_o  = ptr_q;
    mem_re_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    tx_valid_o  = 1'b0;
    done_o      = 1'b0;
    done_to_o   = 1'b0;
    accept_o    = 1'b0;
    start_ok_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          start_ok_o = 1'b1;
          state_d    = dir_i ? ST_TX_RD : ST_RX_WAIT;
        end
      end
      ST_TX_RD: begin
        mem_re_o = 1'b1;
        state_d  = ST_TX_CHK;
      end
      ST_TX_CHK: begin
        if (mem_mark_i) begin
          done_o  = 1'b1;
          state_d = ST_IDLE;
        end else if (wide_q) begin
          mem_addr_o = ptr_q + STEP1;
          mem_re_o   = 1'b1;
          state_d    = ST_TX_LO;
        end else begin
          state_d = ST_TX_SEND;
        end
      end
      ST_TX_LO: state_d = ST_TX_SEND;
      ST_TX_SEND: begin
        tx_valid_o = 1'b1;
        if (tx_ready_i) state_d = ST_TX_RD;
      end
      ST_RX_WAIT: begin
        if (rx_valid_i) begin
          accept_o = 1'b1;
          state_d  = wide_q ? ST_RX_HI : ST_RX_RD;
        end
      end
      ST_RX_HI: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = {{(FRAME_W-HI_W){1'b0}}, char_q[CHAR_W-1:FRAME_W]};
        state_d     = ST_RX_RD;
      end
      ST_RX_RD: begin
        mem_re_o = 1'b1;
        state_d  = ST_RX_CHK;
      end
      ST_RX_CHK: begin
        // final location is written, then released
        mem_we_o    = 1'b1;
        mem_wdata_o = char_q[FRAME_W-1:0];
        if (mem_mark_i) begin
          done_o  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_RX_WAIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (expire_i && state_q != ST_IDLE && !done_o) begin
      done_o    = 1'b1;
      done_to_o = 1'b1;
      state_d   = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      wide_q  <= 1'b0;
      dir_q   <= DIR_RX;
      hi_q    <= '0;
      char_q  <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ptr_q  <= base_i;
          wide_q <= wide_i;
          dir_q  <= xfer_dir_e'(dir_i);
        end
        ST_TX_CHK: if (!mem_mark_i) begin
          if (wide_q) hi_q   <= mem_rdata_i[HI_W-1:0];
          else        char_q <= {{HI_W{1'b0}}, mem_rdata_i};
        end
        ST_TX_LO:   char_q <= {hi_q, mem_rdata_i};
        ST_TX_SEND: if (tx_ready_i) ptr_q <= ptr_q + (wide_q ? STEP2 : STEP1);
        ST_RX_WAIT: if (rx_valid_i) char_q <= rx_char_i;
        ST_RX_HI:   ptr_q <= ptr_q + STEP1;
        ST_RX_CHK:  if (!mem_mark_i) ptr_q <= ptr_q + STEP1;
        default: ;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign dir_o     = dir_q;
  assign tx_char_o = char_q;
endmodule

// File: rtl/rm_block_chan.sv
module rm_block_chan
  import rm_chan_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned TIMEOUT_CYC = 1500000000,
  parameter int unsigned TAIL_CYC    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              start_dir_i,
  input  logic              start_wide_i,
  input  logic [ADDR_W-1:0] start_base_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [5:0]        mem_wdata_o,
  input  logic [5:0]        mem_rdata_i,
  input  logic              mem_imark_i,
  input  logic              mem_wmark_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_char_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_char_o,
  input  logic              tx_ready_i,
  input  logic              line_idle_i,
  output logic              chan_busy_o,
  output logic              dev_busy_o,
  output logic              released_o,
  output logic              timeout_err_o,
  output logic              in_demand_o,
  output logic              tx_irq_o
);
  logic      busy, expire, done, done_to, accept, start_ok, kick;
  xfer_dir_e dir;
  logic      released_q, err_q, seen_q, ifd_q, pend_q, irq_q;

  assign kick = rx_valid_i || (tx_valid_o && tx_ready_i);

  rm_idle_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk_i, .rst_ni, .run_i(busy), .kick_i(kick), .expire_o(expire)
  );

  rm_xfer_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i, .dir_i(start_dir_i), .wide_i(start_wide_i), .base_i(start_base_i),
    .expire_i(expire),
    .mem_rdata_i, .mem_mark_i(mem_imark_i && mem_wmark_i),
    .mem_addr_o, .mem_re_o, .mem_we_o, .mem_wdata_o,
    .rx_valid_i, .rx_char_i, .tx_ready_i, .tx_valid_o, .tx_char_o,
    .busy_o(busy), .dir_o(dir), .start_ok_o(start_ok),
    .done_o(done), .done_to_o(done_to), .accept_o(accept)
  );

  rm_busy_tail #(.TAIL(TAIL_CYC)) u_tail (
    .clk_i, .rst_ni, .busy_i(busy), .busy_o(dev_busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      released_q <= 1'b0;
      err_q      <= 1'b0;
      seen_q     <= 1'b0;
      ifd_q      <= 1'b0;
      pend_q     <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      released_q <= done;
      if (start_ok)     err_q <= 1'b0;
      else if (done_to) err_q <= 1'b1;
      if (start_ok)    seen_q <= 1'b0;
      else if (accept) seen_q <= 1'b1;
      ifd_q <= accept && !seen_q;
      irq_q <= pend_q && line_idle_i;
      if (done && dir == DIR_TX)      pend_q <= 1'b1;
      else if (pend_q && line_idle_i) pend_q <= 1'b0;
    end
  end

  assign chan_busy_o   = busy;
  assign released_o    = released_q;
  assign timeout_err_o = err_q;
  assign in_demand_o   = ifd_q;
  assign tx_irq_o      = irq_q;
endmodule

// File: rtl/rm_block_chan_chk.sv
module rm_block_chan_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic mem_re_o,
  input logic mem_we_o,
  input logic tx_valid_o,
  input logic line_idle_i,
  input logic chan_busy_o,
  input logic dev_busy_o,
  input logic released_o,
  input logic timeout_err_o,
  input logic in_demand_o,
  input logic tx_irq_o
);
  // R7
  released_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    released_o |-> !chan_busy_o);
  // R10
  dev_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_busy_o |-> dev_busy_o);
  // R10
  dev_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chan_busy_o) |-> dev_busy_o);
  // R11
  irq_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> $past(line_idle_i));
  // R2
  tx_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> chan_busy_o);
  // R4
  we_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> chan_busy_o);
  // R4
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  // R8
  demand_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_demand_o |-> chan_busy_o);
  // R9
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_err_o && !start_i) |=> timeout_err_o);
endmodule

bind rm_block_chan rm_block_chan_chk u_chk (
  .clk_i, .rst_ni, .start_i, .mem_re_o, .mem_we_o, .tx_valid_o, .line_idle_i,
  .chan_busy_o, .dev_busy_o, .released_o, .timeout_err_o, .in_demand_o, .tx_irq_o
);

// File: tb/rm_block_chan_test.sv
module rm_block_chan_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int TO = 300;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, start_dir_i = 0, start_wide_i = 0;
  logic [AW-1:0] start_base_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic mem_re_o, mem_we_o;
  logic [5:0] mem_wdata_o;
  logic [5:0] mem_rdata_i = '0;
  logic mem_imark_i = 0, mem_wmark_i = 0;
  logic rx_valid_i = 0;
  logic [7:0] rx_char_i = '0;
  logic tx_valid_o;
  logic [7:0] tx_char_o;
  logic tx_ready_i = 0;
  logic line_idle_i = 1;
  logic chan_busy_o, dev_busy_o, released_o, timeout_err_o, in_demand_o, tx_irq_o;

  int compared = 0, mismatched = 0;
  int rel_cnt = 0, irq_cnt = 0, ifd_cnt = 0, tail_run = 0, last_tail = -1, lc = 0;
  logic [7:0] exp_q[$];
  logic [5:0] mdat [64];
  logic mim [64];
  logic mwm [64];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rm_block_chan #(.ADDR_W(AW), .TIMEOUT_CYC(TO)) uut (.*);

  // memory model: registered read, writes touch data only
  always @(posedge clk_i) begin
    if (mem_we_o) mdat[mem_addr_o] <= mem_wdata_o;
    if (mem_re_o) begin
      mem_rdata_i <= mdat[mem_addr_o];
      mem_imark_i <= mim[mem_addr_o];
      mem_wmark_i <= mwm[mem_addr_o];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // line model and scoreboard monitor
  always @(negedge clk_i) begin
    tx_ready_i = (lc % 3 == 0);
    lc++;
    if (tx_valid_o && tx_ready_i) begin
      if (exp_q.size() == 0) check(0, "R2/R3 unexpected char", tx_char_o, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(tx_char_o == e, "R2/R3 tx char", tx_char_o, e);
      end
    end
    if (released_o) rel_cnt++;
    if (tx_irq_o) irq_cnt++;
    if (in_demand_o) ifd_cnt++;
    if (chan_busy_o) tail_run = 0;
    else if (dev_busy_o) tail_run++;
    else if (tail_run != 0) begin last_tail = tail_run; tail_run = 0; end
  end

  task automatic start_xfer(input bit dir, input bit wide, input logic [AW-1:0] base);
    @(negedge clk_i);
    start_i = 1; start_dir_i = dir; start_wide_i = wide; start_base_i = base;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic send_rx(input logic [7:0] c);
    @(negedge clk_i);
    rx_valid_i = 1; rx_char_i = c;
    @(negedge clk_i);
    rx_valid_i = 0;
    repeat (12) @(negedge clk_i);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && chan_busy_o; i++) @(negedge clk_i);
    repeat (6) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int r0, i0, f0;
    for (int i = 0; i < 64; i++) begin mdat[i] = 6'h2D; mim[i] = 0; mwm[i] = 0; end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!chan_busy_o && !dev_busy_o && !released_o && !timeout_err_o, "R1 status", chan_busy_o, 0);
    check(!in_demand_o && !tx_irq_o && !tx_valid_o && !mem_we_o && !mem_re_o, "R1 outputs", tx_valid_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    // R2 + R6: narrow transmit, single tags are data, irq waits on line idle (R11)
    mdat[4] = 6'h11; mdat[5] = 6'h22; mim[5] = 1; mdat[6] = 6'h3F; mwm[6] = 1;
    mim[7] = 1; mwm[7] = 1;
    exp_q.push_back(8'h11); exp_q.push_back(8'h22); exp_q.push_back(8'h3F);
    line_idle_i = 0;
    r0 = rel_cnt; i0 = irq_cnt;
    start_xfer(1, 0, 6'd4);
    wait_idle();
    check(exp_q.size() == 0, "R2 R6 all chars sent", exp_q.size(), 0);
    check(rel_cnt - r0 == 1, "R7 one release pulse", rel_cnt - r0, 1);
    check(last_tail == 2, "R10 tail length", last_tail, 2);
    repeat (10) @(negedge clk_i);
    check(irq_cnt == i0, "R11 irq held while line busy", irq_cnt - i0, 0);
    line_idle_i = 1;
    repeat (4) @(negedge clk_i);
    check(irq_cnt - i0 == 1, "R11 irq after idle", irq_cnt - i0, 1);

    // R3: wide transmit, mark on odd location is data
    mdat[16] = 6'h02; mdat[17] = 6'h25; mim[17] = 1; mwm[17] = 1;
    mdat[18] = 6'h00; mdat[19] = 6'h3C; mim[20] = 1; mwm[20] = 1;
    exp_q.push_back(8'hA5); exp_q.push_back(8'h3C);
    r0 = rel_cnt; i0 = irq_cnt;
    start_xfer(1, 1, 6'd16);
    wait_idle();
    check(exp_q.size() == 0, "R3 all wide chars sent", exp_q.size(), 0);
    check(rel_cnt - r0 == 1 && irq_cnt - i0 == 1, "R3 R11 release and irq", irq_cnt - i0, 1);

    // R4 narrow receive, R8 demand, R12 idle rx ignored
    mim[34] = 1; mwm[34] = 1;
    r0 = rel_cnt; i0 = irq_cnt; f0 = ifd_cnt;
    start_xfer(0, 0, 6'd32);
    send_rx(8'h05); send_rx(8'hEA); send_rx(8'h3F);
    wait_idle();
    check(mdat[32] == 6'h05, "R4 loc0", mdat[32], 6'h05);
    check(mdat[33] == 6'h2A, "R4 loc1", mdat[33], 6'h2A);
    check(mdat[34] == 6'h3F, "R4 marked loc written", mdat[34], 6'h3F);
    check(mim[34] && mwm[34], "R4 tags kept", mim[34], 1);
    check(ifd_cnt - f0 == 1, "R8 single demand", ifd_cnt - f0, 1);
    check(rel_cnt - r0 == 1 && irq_cnt == i0, "R7 R11 rx release no irq", irq_cnt - i0, 0);
    check(last_tail == 2, "R10 tail after rx", last_tail, 2);
    send_rx(8'h15);
    check(!chan_busy_o && mdat[35] == 6'h2D, "R12 idle rx ignored", mdat[35], 6'h2D);

    // R5 wide receive, R12 start while busy ignored
    mim[43] = 1; mwm[43] = 1;
    f0 = ifd_cnt;
    start_xfer(0, 1, 6'd40);
    send_rx(8'hC7);
    start_xfer(1, 0, 6'd4);
    send_rx(8'h5E);
    wait_idle();
    check(mdat[40] == 6'h03, "R5 hi0", mdat[40], 6'h03);
    check(mdat[41] == 6'h07, "R5 lo0", mdat[41], 6'h07);
    check(mdat[42] == 6'h01, "R5 hi1", mdat[42], 6'h01);
    check(mdat[43] == 6'h1E, "R5 lo1", mdat[43], 6'h1E);
    check(mdat[44] == 6'h2D, "R12 start ignored, no overrun", mdat[44], 6'h2D);
    check(ifd_cnt - f0 == 1, "R8 demand wide", ifd_cnt - f0, 1);

    // R9 inactivity timeout
    r0 = rel_cnt;
    start_xfer(0, 0, 6'd48);
    @(negedge clk_i); rx_valid_i = 1; rx_char_i = 8'h09;
    @(negedge clk_i); rx_valid_i = 0;
    repeat (TO - 30) @(negedge clk_i);
    check(chan_busy_o && !timeout_err_o, "R9 still held before limit", chan_busy_o, 1);
    repeat (60) @(negedge clk_i);
    check(!chan_busy_o && timeout_err_o, "R9 forced release", timeout_err_o, 1);
    check(rel_cnt - r0 == 1 && mdat[48] == 6'h09, "R9 release pulse and stored", rel_cnt - r0, 1);
    repeat (20) @(negedge clk_i);
    check(timeout_err_o, "R9 error held", timeout_err_o, 1);
    start_xfer(0, 0, 6'd50);
    check(!timeout_err_o, "R9 error cleared by start", timeout_err_o, 0);
    repeat (TO + 40) @(negedge clk_i);
    check(!chan_busy_o, "R9 second timeout", chan_busy_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule